// File: doc/BRIEF.md
# Packed BCD String Arithmetic Sequencer

This block is a multi-cycle engine that adds, subtracts or compares two decimal numbers stored as packed-BCD strings in a byte-wide memory. Each byte holds two decimal digits, with the less significant digit in bits 3:0. A string starts at its least significant byte, and the more significant bytes sit at increasing addresses. A host gives a one-cycle start pulse together with an operation code, a source pointer, a destination pointer and a digit count. The engine then walks both strings from the low end. In the add and subtract modes it writes each result byte back over the destination string. In compare mode it writes nothing to memory and only produces flags.

The engine reaches memory through a synchronous port with a one-cycle read latency: read data appears on `mem_rdata` in the cycle after `mem_rd` is asserted. The duration of every operation is fixed in advance and depends only on the digit count. This lets the surrounding pipeline stall for a known number of cycles. The carry, overflow and zero flags change only when an operation completes.

Top module: `bcd_string_engine`

## Requirements
- R1: After reset, `busy` is low, `flag_cy`, `flag_ov` and `flag_z` are 0, and neither `mem_rd` nor `mem_wr` is asserted.
- R2: A start pulse taken while idle makes `busy` high from the next cycle for exactly 19*floor(count/2)+7 cycles. A start pulse given while `busy` is high is ignored and does not change the running operation.
- R3: With `op`=00 (add), destination plus source is computed in decimal, one byte at a time from the lowest address. Each result byte is written to the destination byte it came from, and the source string is left unchanged.
- R4: With `op`=01 (subtract), destination minus source is computed in ten's complement, and the result replaces the destination string.
- R5: With `op`=10 or `op`=11 (compare), the same subtraction as R4 is done and the flags are set as for R4, but `mem_wr` is never asserted.
- R6: `flag_cy` holds the final carry (add) or borrow (subtract or compare) out of the most significant digit.
- R7: `flag_z` is 1 only when every result digit of the whole string is zero.
- R8: `flag_ov` reports signed ten's-complement overflow. The top digit of each string is taken as negative when it is 5 or more. For add, the flag is set when both operands have the same sign and the result's sign differs from it. For subtract, it is set when the operand signs differ and the result's sign differs from the destination's sign.
- R9: An odd digit count is rounded down to whole bytes, and the byte just past the processed range is never read or written.
- R10: A digit count below 2 performs no memory access, keeps `busy` high for 7 cycles, and ends with `flag_z`=1, `flag_cy`=0 and `flag_ov`=0.
- R11: The flags hold their values while `busy` is high and take their new values on the cycle `busy` falls.
- R12: Every write goes to the address read as destination four cycles earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to begin an operation |
| op | input | 2 | 00 add, 01 subtract, 1x compare |
| src_ptr | input | AW | Address of the source string's least significant byte |
| dst_ptr | input | AW | Address of the destination string's least significant byte |
| digits | input | CW | String length in BCD digits |
| busy | output | 1 | Operation in progress |
| mem_addr | output | AW | Memory address |
| mem_rd | output | 1 | Read request; data is returned one cycle later |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data |
| flag_cy | output | 1 | Carry / borrow out |
| flag_ov | output | 1 | Signed decimal overflow |
| flag_z | output | 1 | All result digits zero |

## Verification
The bench aims at carries and borrows that ripple across every digit. Adding 1 to a string of all 9s, or subtracting 1 from a string of all 0s, shows whether the carry or borrow is chained between nibbles and between bytes. A design that drops the carry leaves stray 9s or 0s in the result and a clear carry flag. Compare runs on equal strings check that no write occurs and that the zero flag is built over the whole string, not only the last byte. Zero and odd counts check the cycle count and the byte just past the string, where an off-by-one walk would corrupt memory. A start pulse given in the middle of a run checks that the running operation is not restarted or switched to another mode.

// File: rtl/bcd_string_engine.sv
module bcd_string_engine #(
  parameter int AW = 16,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    op,
  input  logic [AW-1:0] src_ptr,
  input  logic [AW-1:0] dst_ptr,
  input  logic [CW-1:0] digits,
  output logic          busy,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [7:0]    mem_wdata,
  input  logic [7:0]    mem_rdata,
  output logic          flag_cy,
  output logic          flag_ov,
  output logic          flag_z
);
  localparam int BW = CW - 1;
  localparam logic [4:0] LAST_STEP = 5'd18;
  localparam logic [2:0] HEAD = 3'd7;
  localparam logic [1:0] OP_ADD = 2'b00;

  logic [2:0]    hd;
  logic [BW-1:0] nb;
  logic [4:0]    stp;
  logic [1:0]    mode;
  logic [AW-1:0] sp, dp;
  logic [7:0]    sb, db, res;
  logic          cy_w, z_w, ov_w;
  logic          walk, sub, fin;
  logic [4:0]    lo_t, hi_t;

  function automatic logic [4:0] dig(input logic [3:0] d, input logic [3:0] a,
                                     input logic c, input logic s);
    logic [4:0] t;
    if (!s) begin
      t = {1'b0, d} + {1'b0, a} + {4'd0, c};
      if (t > 5'd9) t = t + 5'd6;
    end else begin
      t = {1'b0, d} - {1'b0, a} - {4'd0, c};
      if (t[4]) t = t - 5'd6;
    end
    return t;
  endfunction

  assign busy      = (hd != 3'd0) || (nb != '0);
  assign walk      = (hd == 3'd0) && (nb != '0);
  assign sub       = (mode != OP_ADD);
  assign mem_rd    = walk && (stp == 5'd0 || stp == 5'd1);
  assign mem_wr    = walk && (stp == 5'd5) && !mode[1];
  assign mem_addr  = (stp == 5'd0) ? sp : dp;
  assign mem_wdata = res;
  assign lo_t      = dig(db[3:0], sb[3:0], cy_w, sub);
  assign hi_t      = dig(db[7:4], sb[7:4], cy_w, sub);
  assign fin       = (hd == 3'd1 && nb == '0) ||
                     (hd == 3'd0 && nb == BW'(1) && stp == LAST_STEP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hd <= '0; nb <= '0; stp <= '0; mode <= '0;
      sp <= '0; dp <= '0; sb <= '0; db <= '0; res <= '0;
      cy_w <= 1'b0; z_w <= 1'b1; ov_w <= 1'b0;
      flag_cy <= 1'b0; flag_ov <= 1'b0; flag_z <= 1'b0;
    end else begin
      if (fin) begin
        flag_cy <= cy_w;
        flag_ov <= ov_w;
        flag_z  <= z_w;
      end
      if (!busy) begin
        if (start) begin
          hd   <= HEAD;
          nb   <= digits[CW-1:1];
          stp  <= '0;
          mode <= op;
          sp   <= src_ptr;
          dp   <= dst_ptr;
          cy_w <= 1'b0;
          z_w  <= 1'b1;
          ov_w <= 1'b0;
        end
      end else if (hd != 3'd0) begin
        hd <= hd - 3'd1;
      end else begin
        case (stp)
          5'd1: sb <= mem_rdata;
          5'd2: db <= mem_rdata;
          5'd3: begin
            res[3:0] <= lo_t[3:0];
            cy_w     <= lo_t[4];
            if (lo_t[3:0] != 4'd0) z_w <= 1'b0;
          end
          5'd4: begin
            res[7:4] <= hi_t[3:0];
            cy_w     <= hi_t[4];
            if (hi_t[3:0] != 4'd0) z_w <= 1'b0;
            if (nb == BW'(1)) begin
              if (!sub)
                ov_w <= ((db[7:4] >= 4'd5) == (sb[7:4] >= 4'd5)) &&
                        ((hi_t[3:0] >= 4'd5) != (db[7:4] >= 4'd5));
              else
                ov_w <= ((db[7:4] >= 4'd5) != (sb[7:4] >= 4'd5)) &&
                        ((hi_t[3:0] >= 4'd5) != (db[7:4] >= 4'd5));
            end
          end
          default: ;
        endcase
        if (stp == LAST_STEP) begin
          stp <= '0;
          nb  <= nb - BW'(1);
          sp  <= sp + AW'(1);
          dp  <= dp + AW'(1);
        end else begin
          stp <= stp + 5'd1;
        end
      end
    end
  end

  // R1: nothing touches memory while idle
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_rd && !mem_wr);

  // R2: an accepted start raises busy on the next cycle
  p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy);

  // R5: compare mode never writes
  p_cmp_no_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy && mode[1] |-> !mem_wr);

  // R11: flags hold while an operation runs
  p_flags_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable({flag_cy, flag_ov, flag_z}));

  // R12: a write lands on the destination byte read four cycles earlier
  p_wr_to_dst_r12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> $past(mem_rd, 4) && (mem_addr == $past(mem_addr, 4)));

  // R10: a short count issues no memory access at all
  p_short_no_access_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy && nb == '0 |-> !mem_rd && !mem_wr);
endmodule

// File: tb/bcd_string_engine_bench.sv
`timescale 1ns/1ps
module bcd_string_engine_bench;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [1:0] op = 2'b00;
  logic [15:0] src_ptr = '0, dst_ptr = '0;
  logic [7:0] digits = '0;
  logic busy, mem_rd, mem_wr, flag_cy, flag_ov, flag_z;
  logic [15:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata;

  logic [7:0] mem [0:255];
  logic [7:0] ref_mem [0:255];
  int n_rd = 0, n_wr = 0, cycles = 0, errors = 0, checks = 0;

  always #2.5 clk = ~clk;

  bcd_string_engine u_bcd_string_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .src_ptr(src_ptr),
    .dst_ptr(dst_ptr), .digits(digits), .busy(busy), .mem_addr(mem_addr),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .flag_cy(flag_cy), .flag_ov(flag_ov), .flag_z(flag_z));

  always @(posedge clk) begin
    if (mem_wr) begin mem[mem_addr[7:0]] <= mem_wdata; n_wr <= n_wr + 1; end
    if (mem_rd) begin mem_rdata <= mem[mem_addr[7:0]]; n_rd <= n_rd + 1; end
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual=%0d expected=<150000 cycles", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] rnd_bcd();
    return {4'($urandom % 10), 4'($urandom % 10)};
  endfunction

  task automatic ref_op(input int opc, input int s, input int d, input int dg,
                        output bit cy, output bit ov, output bit z);
    int c = 0;
    cy = 0; ov = 0; z = 1;
    for (int i = 0; i < dg / 2; i++) begin
      int a = ref_mem[s + i], b = ref_mem[d + i], r = 0;
      for (int k = 0; k < 2; k++) begin
        int da = (a >> (4 * k)) & 15, db = (b >> (4 * k)) & 15, t;
        if (opc == 0) begin
          t = db + da + c; c = (t > 9) ? 1 : 0; if (c == 1) t -= 10;
        end else begin
          t = db - da - c; c = (t < 0) ? 1 : 0; if (c == 1) t += 10;
        end
        if (t != 0) z = 0;
        r = r | (t << (4 * k));
        if (k == 1 && i == dg / 2 - 1) begin
          bit sa = (da >= 5), sd = (db >= 5), sr = (t >= 5);
          ov = (opc == 0) ? ((sa == sd) && (sr != sd)) : ((sa != sd) && (sr != sd));
        end
      end
      if (opc < 2) ref_mem[d + i] = 8'(r);
    end
    cy = (c == 1);
  endtask

  // runs one operation; poke >= 0 issues a spurious subtract start at that busy cycle
  task automatic run(input int opc, input int s, input int d, input int dg,
                     input int poke, input string req);
    bit ecy, eov, ez;
    int cyc = 0, rd0, wr0, bad = 0, first = -1;
    for (int i = 0; i < 256; i++) ref_mem[i] = mem[i];
    ref_op(opc, s, d, dg, ecy, eov, ez);
    rd0 = n_rd; wr0 = n_wr;
    @(negedge clk);
    start = 1; op = 2'(opc); src_ptr = 16'(s); dst_ptr = 16'(d); digits = 8'(dg);
    @(negedge clk);
    start = 0;
    while (busy) begin
      cyc++;
      if (cyc == poke) begin start = 1; op = 2'b01; digits = 8'd2; end
      else start = 0;
      @(negedge clk);
    end
    start = 0;
    check(cyc == 19 * (dg / 2) + 7, {req, " R2 busy length"}, cyc, 19 * (dg / 2) + 7);
    check(flag_cy == ecy, {req, " R6 carry"}, flag_cy, ecy);
    check(flag_z == ez, {req, " R7 zero"}, flag_z, ez);
    check(flag_ov == eov, {req, " R8 overflow"}, flag_ov, eov);
    for (int i = 0; i < 256; i++)
      if (mem[i] !== ref_mem[i]) begin bad++; if (first < 0) first = i; end
    check(bad == 0, {req, " R3/R4/R5 memory image"},
          (first < 0) ? 0 : mem[first], (first < 0) ? 0 : ref_mem[first]);
    if (opc >= 2) check(n_wr == wr0, {req, " R5 no writes"}, n_wr - wr0, 0);
    if (dg < 2) check(n_rd == rd0 && n_wr == wr0, {req, " R10 no access"}, n_rd - rd0, 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 256; i++) mem[i] = rnd_bcd();
    repeat (3) @(negedge clk);
    check(!busy && !mem_rd && !mem_wr, "R1 idle in reset", busy, 0);
    rst_n = 1;
    @(negedge clk);
    check(flag_cy == 0 && flag_ov == 0 && flag_z == 0, "R1 flags after reset",
          {flag_cy, flag_ov, flag_z}, 0);

    // R3/R6: all nines plus one ripples to zero with carry
    for (int i = 0; i < 4; i++) begin mem[8'h80 + i] = 8'h99; mem[8'h10 + i] = 8'h00; end
    mem[8'h10] = 8'h01;
    run(0, 8'h10, 8'h80, 8, -1, "R3 nines plus one");
    check(mem[8'h83] == 8'h00, "R3 top byte", mem[8'h83], 8'h00);

    // R4: zero minus one borrows through every digit
    for (int i = 0; i < 3; i++) begin mem[8'h80 + i] = 8'h00; mem[8'h10 + i] = 8'h00; end
    mem[8'h10] = 8'h01;
    run(1, 8'h10, 8'h80, 6, -1, "R4 borrow through zero");
    check(mem[8'h82] == 8'h99, "R4 top byte", mem[8'h82], 8'h99);

    // R5/R7: compare of equal strings
    for (int i = 0; i < 5; i++) begin mem[8'h10 + i] = rnd_bcd(); mem[8'h80 + i] = mem[8'h10 + i]; end
    run(2, 8'h10, 8'h80, 10, -1, "R5 compare equal");
    check(flag_z == 1, "R7 equal gives zero", flag_z, 1);

    // R5: code 11 also compares
    run(3, 8'h20, 8'h90, 12, -1, "R5 code 11 compare");

    // R10: zero count after a carry-producing run
    for (int i = 0; i < 2; i++) begin mem[8'h80 + i] = 8'h99; mem[8'h10 + i] = 8'h99; end
    run(0, 8'h10, 8'h80, 4, -1, "R6 carry setup");
    run(0, 8'h10, 8'h80, 0, -1, "R10 zero count");
    check(flag_z == 1 && flag_cy == 0 && flag_ov == 0, "R10 flags",
          {flag_cy, flag_ov, flag_z}, 1);
    run(1, 8'h10, 8'h80, 1, -1, "R10 one digit");

    // R9: odd count, byte past the end untouched
    mem[8'h83] = 8'h42;
    run(0, 8'h10, 8'h80, 7, -1, "R9 odd count");
    check(mem[8'h83] == 8'h42, "R9 byte past end", mem[8'h83], 8'h42);

    // R8: overflow cases
    mem[8'h10] = 8'h40; mem[8'h80] = 8'h30;
    run(0, 8'h10, 8'h80, 2, -1, "R8 add overflow");
    check(flag_ov == 1, "R8 add overflow set", flag_ov, 1);
    mem[8'h10] = 8'h60; mem[8'h80] = 8'h30;
    run(1, 8'h10, 8'h80, 2, -1, "R8 sub overflow");

    // R2: start while busy is ignored
    run(0, 8'h20, 8'hA0, 16, 40, "R2 start ignored while busy");

    // random mix
    for (int n = 0; n < 40; n++) begin
      int opc = $urandom % 4;
      int dg = $urandom % 41;
      for (int i = 0; i < 21; i++) begin mem[8'h10 + i] = rnd_bcd(); mem[8'h80 + i] = rnd_bcd(); end
      if (n % 10 == 3) for (int i = 0; i < 21; i++) mem[8'h80 + i] = 8'h99;
      if (n % 10 == 7) for (int i = 0; i < 21; i++) mem[8'h80 + i] = 8'h00;
      run(opc, 8'h10, 8'h80, dg, -1, "random");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule